// File: doc/BRIEF.md
# Sampled Push-Button Debouncer

This block turns one noisy mechanical push-button into a clean, clock-domain-safe signal. The raw contact is active-low and arrives with no timing relation to the system clock. A short flip-flop chain first retimes it into the system clock domain. After that, the block reads the retimed value only on cycles where a periodic sample tick is high. The tick is typically one per millisecond, generated elsewhere.

A four-state machine keeps track of the button. It has a known-released state, a pending-press state, a known-pressed state and a pending-release state. Leaving either stable state takes an unbroken run of `CONFIRM_SAMPLES` samples that disagree with that state. A single sample that agrees with the old state during the run cancels it, and the block falls back to where it was. The block drives a debounced hold level. It also drives a one-cycle strobe for each confirmed press, so a counter downstream sees exactly one event per press, however much the contacts bounce.

Top module: `sampled_debouncer`

## Requirements
- R1: After reset, `btn_held` and `press_pulse` are 0 and the run count is cleared, so a press run that was partly counted before reset must start again from zero afterwards.
- R2: `btn_raw_n` is active-low: 0 means the switch is closed (pressed) and 1 means it is open (released).
- R3: The raw input passes through `SYNC_STAGES` flip-flops before the state machine reads it, so a tick in the same cycle as a raw change still samples the old value.
- R4: On cycles without `sample_tick`, the state does not move, whatever `btn_raw_n` does.
- R5: A press is accepted only after `CONFIRM_SAMPLES` consecutive ticks that all read pressed; one fewer is not enough.
- R6: A released sample during a pending press cancels it: the block returns to released and the next press needs a full new run.
- R7: `press_pulse` is high for exactly one clock cycle per accepted press, on the first cycle of the pressed state, and never at any other time.
- R8: A release is accepted only after `CONFIRM_SAMPLES` consecutive ticks that all read released; until then `btn_held` stays 1.
- R9: A pressed sample during a pending release returns the block to the pressed state without a new `press_pulse`, and a later release needs a full new run.
- R10: `btn_held` is 1 from the cycle a press is accepted until the cycle a release is accepted, and it rises in the same cycle as `press_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| sample_tick | input | 1 | One-cycle sample enable from a periodic timer |
| btn_raw_n | input | 1 | Raw button contact, active-low, asynchronous |
| btn_held | output | 1 | Debounced level, 1 while the button counts as pressed |
| press_pulse | output | 1 | One-cycle strobe when a press is accepted |

## Verification
The bench builds the block with `CONFIRM_SAMPLES` = 4 and `SYNC_STAGES` = 3. The short run length puts the one-short boundary, cancelled runs and runs restarted after reset within a few dozen ticks. The three-stage chain makes the retiming delay deep enough to test by firing a tick in the same cycle as a raw edge. A scoreboard predicts each press strobe and each release from its own count of contrary samples. It then matches them, in order, against the outputs.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  typedef enum logic [1:0] {
    ST_OPEN      = 2'd0,
    ST_PEND_DOWN = 2'd1,
    ST_DOWN      = 2'd2,
    ST_PEND_UP   = 2'd3
  } dbn_state_e;

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  // Reset to 1: an open contact reads high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/dbn_run_counter.sv
module dbn_run_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/dbn_fsm.sv
module dbn_fsm
  import dbn_pkg::*;
#(
  parameter int N  = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          closed,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          held,
  output logic          pulse
);

  localparam logic [CW:0] LIMIT = (CW+1)'(N);

  dbn_state_e state_q, state_d;
  logic       pulse_d;
  logic [CW:0] run_len;

  // In a stable state the count is zero, so run_len is 1 for the first contrary sample.
  assign run_len = {1'b0, cnt} + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    pulse_d = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_OPEN, ST_PEND_DOWN: begin
          if (closed) begin
            if (run_len >= LIMIT) begin
              state_d = ST_DOWN;
              cnt_clr = 1'b1;
              pulse_d = 1'b1;
            end else begin
              state_d = ST_PEND_DOWN;
              cnt_inc = 1'b1;
            end
          end else begin
            state_d = ST_OPEN;
            cnt_clr = 1'b1;
          end
        end
        ST_DOWN, ST_PEND_UP: begin
          if (!closed) begin
            if (run_len >= LIMIT) begin
              state_d = ST_OPEN;
              cnt_clr = 1'b1;
            end else begin
              state_d = ST_PEND_UP;
              cnt_inc = 1'b1;
            end
          end else begin
            state_d = ST_DOWN;
            cnt_clr = 1'b1;
          end
        end
        default: begin
          state_d = ST_OPEN;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      pulse   <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse   <= pulse_d;
    end
  end

  assign held = (state_q == ST_DOWN) || (state_q == ST_PEND_UP);

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R7
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(tick)); // R7
  AST_PULSE_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> held); // R10
  AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < LIMIT); // R5
  AST_HELD_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> pulse); // R10

endmodule

// File: rtl/sampled_debouncer.sv
module sampled_debouncer #(
  parameter int CONFIRM_SAMPLES = 10,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic btn_raw_n,
  output logic btn_held,
  output logic press_pulse
);

  localparam int CW = (CONFIRM_SAMPLES < 2) ? 1 : $clog2(CONFIRM_SAMPLES);

  logic          raw_sync_n;
  logic          closed;
  logic          cnt_clr;
  logic          cnt_inc;
  logic [CW-1:0] run_cnt;

  dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (btn_raw_n),
    .sync_out (raw_sync_n)
  );

  // Active-low contact: 0 on the line means pressed.
  assign closed = ~raw_sync_n;

  dbn_run_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (run_cnt)
  );

  dbn_fsm #(.N(CONFIRM_SAMPLES), .CW(CW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_tick),
    .closed  (closed),
    .cnt     (run_cnt),
    .cnt_clr (cnt_clr),
    .cnt_inc (cnt_inc),
    .held    (btn_held),
    .pulse   (press_pulse)
  );

endmodule

// File: tb/tb_sampled_debouncer.sv
module tb_sampled_debouncer;

  localparam int N  = 4;
  localparam int SS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic btn_raw_n = 1'b1;
  logic btn_held;
  logic press_pulse;

  int total = 0;
  int bad = 0;
  int presses_exp = 0;
  int presses_seen = 0;
  bit done = 0;

  // Scoreboard items: 1 = press accepted, 2 = release accepted.
  int exp_q[$];

  // Reference: current debounced level and run of contrary samples.
  bit m_held = 0;
  int m_run = 0;

  always #5 clk = ~clk;

  sampled_debouncer #(.CONFIRM_SAMPLES(N), .SYNC_STAGES(SS)) dut (
    .clk (clk), .rst_n (rst_n), .sample_tick (sample_tick),
    .btn_raw_n (btn_raw_n), .btn_held (btn_held), .press_pulse (press_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model fed with the value the sampler sees (1 = pressed).
  task automatic model_sample(input bit pressed);
    if (pressed != m_held) begin
      m_run++;
      if (m_run == N) begin
        m_held = pressed;
        m_run = 0;
        if (pressed) begin
          exp_q.push_back(1);
          presses_exp++;
        end else begin
          exp_q.push_back(2);
        end
      end
    end else begin
      m_run = 0;
    end
  endtask

  // Driver: set the raw line, let it cross the chain, then one tick.
  task automatic sample(input bit pressed);
    @(negedge clk);
    btn_raw_n = ~pressed;
    repeat (SS + 1) @(negedge clk);
    model_sample(pressed);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  task automatic run(input bit pressed, input int n);
    for (int i = 0; i < n; i++) sample(pressed);
  endtask

  // Monitor: pops the scoreboard as results appear.
  bit prev_held = 0;
  bit prev_pulse = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (press_pulse) begin
        presses_seen++;
        check("R7 pulse width", int'(prev_pulse), 0);
        check("R10 level with pulse", int'(btn_held), 1);
        if (exp_q.size() == 0) check("R7 unexpected pulse", 1, 0);
        else check("R7 press event", exp_q.pop_front(), 1);
      end
      if (btn_held && !prev_held && !press_pulse)
        check("R10 rise without pulse", 0, 1);
      if (!btn_held && prev_held) begin
        if (exp_q.size() == 0) check("R8 unexpected release", 1, 0);
        else check("R8 release event", exp_q.pop_front(), 2);
      end
      prev_held = btn_held;
      prev_pulse = press_pulse;
    end else begin
      prev_held = 0;
      prev_pulse = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 held after reset", int'(btn_held), 0);
    check("R1 pulse after reset", int'(press_pulse), 0);
    rst_n = 1'b1;

    // R4: raw held low for many cycles with no tick
    @(negedge clk); btn_raw_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R4 no tick no move", int'(btn_held), 0);
    btn_raw_n = 1'b1;
    repeat (SS + 2) @(negedge clk);

    // R5, R2: one short, then the confirming sample
    run(1, N - 1);
    check("R5 one short of press", int'(btn_held), 0);
    sample(1);
    check("R5 press accepted", int'(btn_held), 1);

    // R8: one short of release, then release
    run(0, N - 1);
    check("R8 still held", int'(btn_held), 1);
    sample(0);
    check("R8 release accepted", int'(btn_held), 0);

    // R6: contrary sample aborts a pending press
    run(1, N - 1);
    sample(0);
    run(1, N - 1);
    check("R6 restarted run", int'(btn_held), 0);
    sample(1);
    check("R6 full run accepted", int'(btn_held), 1);

    // R9: pressed sample aborts a pending release, no new pulse
    run(0, N - 1);
    sample(1);
    check("R9 back to pressed", int'(btn_held), 1);
    run(0, N - 1);
    check("R9 release run restarted", int'(btn_held), 1);
    sample(0);
    check("R9 release accepted", int'(btn_held), 0);

    // R3: tick in the same cycle as the raw edge sees the old value
    @(negedge clk);
    btn_raw_n = 1'b0;
    sample_tick = 1'b1;
    model_sample(0);
    @(negedge clk);
    sample_tick = 1'b0;
    run(1, N - 1);
    check("R3 retimed sample not counted", int'(btn_held), 0);
    sample(1);
    check("R3 press after chain", int'(btn_held), 1);
    run(0, N);
    check("R3 released again", int'(btn_held), 0);

    // R1: reset in the middle of a pending press clears the run
    run(1, N - 1);
    @(negedge clk); rst_n = 1'b0;
    m_held = 0; m_run = 0;
    repeat (2) @(negedge clk);
    check("R1 held during reset", int'(btn_held), 0);
    rst_n = 1'b1;
    sample(1);
    check("R1 run cleared by reset", int'(btn_held), 0);
    run(1, N - 1);
    check("R1 press after reset", int'(btn_held), 1);
    run(0, N);

    repeat (3) @(negedge clk);
    check("R7 pulse count", presses_seen, presses_exp);
    check("R7 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule